// File: doc/BRIEF.md
# Wake-up and watchdog supervisor

This block paces a sleeping processor and guards it. While the supply is good it drives a free-running wake-up square wave. The processor treats each rising edge as an interrupt. On each one it must answer with a falling edge on its watchdog line. If a whole wake-up cycle passes without that answer, the block pulls the active-low reset output low for one reset delay. It then holds the wake-up output low for a restart delay, and after that wake-up cycles resume.

All timing is counted in ticks of a prescaled enable input. Every interval is a multiple of one base unit of `UNIT_TICKS` ticks:

| Interval | Length |
|---|---|
| Wake-up cycle | 8 units |
| Reset pulse | 1 unit |
| Restart delay | 4 units |

A supply-good input stands for an external voltage monitor. While it is false, reset is held low. When it recovers, reset is released one unit later. If the watchdog input is tied back to the wake-up output, every cycle counts as serviced, and the block acts as a plain wake-up generator with supply supervision.

Top module: `wake_wdt_supervisor`

## Requirements
- R1: While `rst_ni` is low, or `supply_ok_i` is low, `rst_no_o` is 0 and `wake_o` is 0.
- R2: When `supply_ok_i` drops, `rst_no_o` is 0 after the next clock edge, whether or not a tick is present.
- R3: Once `supply_ok_i` is steadily high, `rst_no_o` is released after `UNIT_TICKS` ticks.
- R4: After `rst_no_o` rises, `wake_o` stays low for 4*`UNIT_TICKS` ticks, and then a wake-up cycle starts with `wake_o` high.
- R5: A wake-up cycle lasts 8*`UNIT_TICKS` ticks. `wake_o` is high for the first half and low for the second half, unless it is cut short by service.
- R6: The watchdog input passes through two synchronizer flops and one edge register. The first falling edge of `wdi_i` in a cycle pulls `wake_o` low `LAT_TICKS` ticks after the edge is registered. With a tick on every clock, that is 3+`LAT_TICKS` clocks after `wdi_i` falls. `wake_o` then stays low until the next cycle starts, and the cycle length is unchanged. A falling edge during the low half also counts as service.
- R7: Further falling edges in the same cycle are ignored. Service never carries over into the next cycle.
- R8: A cycle with no falling edge on `wdi_i` ends with `rst_no_o` going low exactly at the cycle end. It stays low for `UNIT_TICKS` ticks, and then the restart of R4 follows.
- R9: `wake_o` is 0 whenever `rst_no_o` is 0.
- R10: With `wdi_i` tied to `wake_o`, no watchdog reset ever occurs.
- R11: All intervals count ticks only. Between ticks, `wake_o` never rises, and `rst_no_o` changes only on loss of supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled timing enable, one clock wide |
| supply_ok_i | input | 1 | Supply-good indication, synchronous to `clk_i` |
| wdi_i | input | 1 | Watchdog service input from the processor (asynchronous) |
| wake_o | output | 1 | Wake-up square wave |
| rst_no_o | output | 1 | Reset to the processor, active low |

## Verification
A phase counter that is off by even one tick shows up at once as a wake-up edge, or a reset edge, at the wrong clock index. The bench therefore predicts the absolute clock index of every such edge and compares them exactly. A service flag that is stuck, or that leaks from one cycle into the next, appears within one cycle: either as a reset edge exactly 8 units after a cycle start that should not have one, or as a missing reset edge where one is expected. A wrong edge-to-cut latency moves the falling edge of `wake_o` in the sweep over service offsets.

// File: rtl/wake_wdt_pkg.sv
package wake_wdt_pkg;
  typedef enum logic [1:0] {
    PH_HOLD    = 2'd0,
    PH_RESTART = 2'd1,
    PH_CYCLE   = 2'd2
  } phase_e;
endpackage

// File: rtl/wdt_fall_detect.sv
module wdt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b1;
      else if (i == 0) sync_q[i] <= async_i;
      else sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/wdt_service_track.sv
module wdt_service_track #(
  parameter int LAT_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic fall_i,
  output logic serviced_o,
  output logic cut_o
);
  localparam int LW = (LAT_TICKS > 1) ? $clog2(LAT_TICKS) : 1;
  localparam logic [LW-1:0] LAT_LAST = LW'(LAT_TICKS - 1);

  logic          run_q;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serviced_o <= 1'b0;
      cut_o      <= 1'b0;
      run_q      <= 1'b0;
      lat_q      <= '0;
    end else if (clr_i) begin
      serviced_o <= 1'b0;
      cut_o      <= 1'b0;
      run_q      <= 1'b0;
      lat_q      <= '0;
    end else begin
      // only the first edge of the cycle starts the latency count
      if (fall_i && !serviced_o) begin
        serviced_o <= 1'b1;
        run_q      <= 1'b1;
        lat_q      <= '0;
      end else if (run_q && tick_i) begin
        if (lat_q == LAT_LAST) begin
          cut_o <= 1'b1;
          run_q <= 1'b0;
        end else begin
          lat_q <= lat_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
  import wake_wdt_pkg::*;
#(
  parameter int UNIT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic serviced_i,
  output logic in_cycle_o,
  output logic first_half_o,
  output logic cycle_end_o,
  output logic rst_no_o
);
  localparam int CYC_TICKS = 8 * UNIT_TICKS;
  localparam int CNT_W     = $clog2(CYC_TICKS);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(UNIT_TICKS - 1);
  localparam logic [CNT_W-1:0] RSTRT_LAST = CNT_W'(4 * UNIT_TICKS - 1);
  localparam logic [CNT_W-1:0] CYC_LAST   = CNT_W'(CYC_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF       = CNT_W'(4 * UNIT_TICKS);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
    end else if (!supply_ok_i) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            phase_q <= PH_RESTART;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_RESTART: begin
          if (cnt_q == RSTRT_LAST) begin
            phase_q <= PH_CYCLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_CYCLE: begin
          if (cnt_q == CYC_LAST) begin
            phase_q <= serviced_i ? PH_CYCLE : PH_HOLD;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          phase_q <= PH_HOLD;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign in_cycle_o   = (phase_q == PH_CYCLE);
  assign first_half_o = (cnt_q < HALF);
  assign cycle_end_o  = tick_i & supply_ok_i & in_cycle_o & (cnt_q == CYC_LAST);
  assign rst_no_o     = (phase_q != PH_HOLD);
endmodule

// File: rtl/wake_wdt_supervisor.sv
module wake_wdt_supervisor #(
  parameter int UNIT_TICKS = 16,
  parameter int LAT_TICKS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic wdi_i,
  output logic wake_o,
  output logic rst_no_o
);
  logic fall, serviced, cut, in_cycle, first_half, cycle_end, clr;

  wdt_fall_detect #(.STAGES(2)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wdi_i),
    .fall_o (fall)
  );

  assign clr = ~in_cycle | cycle_end;

  wdt_service_track #(.LAT_TICKS(LAT_TICKS)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clr_i     (clr),
    .fall_i    (fall),
    .serviced_o(serviced),
    .cut_o     (cut)
  );

  wdt_phase_seq #(.UNIT_TICKS(UNIT_TICKS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .serviced_i  (serviced),
    .in_cycle_o  (in_cycle),
    .first_half_o(first_half),
    .cycle_end_o (cycle_end),
    .rst_no_o    (rst_no_o)
  );

  assign wake_o = in_cycle & first_half & ~cut;
endmodule

// File: rtl/wake_wdt_checker.sv
module wake_wdt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic supply_ok_i,
  input logic wake_o,
  input logic rst_no_o
);
  assert_wake_low_in_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no_o |-> !wake_o);

  assert_supply_loss_resets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !rst_no_o);

  assert_release_needs_supply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no_o) |-> $past(supply_ok_i));

  assert_wake_rise_after_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> (rst_no_o && $past(rst_no_o)));

  assert_wake_rise_on_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(tick_i));

  assert_reset_fall_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no_o) |-> ($past(!supply_ok_i) || $past(tick_i)));
endmodule

bind wake_wdt_supervisor wake_wdt_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .supply_ok_i(supply_ok_i),
  .wake_o     (wake_o),
  .rst_no_o   (rst_no_o)
);

// File: tb/wake_wdt_supervisor_test.sv
`timescale 1ns/1ps
module wake_wdt_supervisor_test;
  localparam int U   = 16;
  localparam int LAT = 2;

  logic clk_i = 1'b0;
  logic rst_ni, tick_i, supply_ok_i, wdi_drv, loop_en, wdi_i;
  logic wake_o, rst_no_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  assign wdi_i = loop_en ? wake_o : wdi_drv;

  wake_wdt_supervisor #(.UNIT_TICKS(U), .LAT_TICKS(LAT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .wdi_i(wdi_i), .wake_o(wake_o), .rst_no_o(rst_no_o)
  );

  int checks = 0, fails = 0;
  int t = 0;
  bit slow = 0;
  bit pw = 0, pr = 0;
  int last_rise = -1, last_fall = -1, last_per = 0, last_hw = 0;
  int last_rst_rise = -1, last_rst_fall = -1, rst_falls = 0, wake_in_rst = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
    t++;
    if (wake_o && !pw) begin
      if (last_rise >= 0) last_per = t - last_rise;
      last_rise = t;
    end
    if (!wake_o && pw) begin
      last_fall = t;
      last_hw = t - last_rise;
    end
    if (rst_no_o && !pr) last_rst_rise = t;
    if (!rst_no_o && pr && rst_ni) begin
      last_rst_fall = t;
      rst_falls++;
    end
    if (!rst_no_o && wake_o) wake_in_rst++;
    pw = wake_o;
    pr = rst_no_o;
    tick_i = slow ? (t % 3 == 0) : 1'b1;
  endtask

  task automatic step_to(input int target);
    while (t < target) step();
  endtask

  task automatic pulse_wdi();
    wdi_drv = 1'b0;
    step();
    step();
    wdi_drv = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", t);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n0, c0, c4, c5, c6, c7, d0, d1, s;
    rst_ni = 0; tick_i = 1; supply_ok_i = 0; wdi_drv = 1; loop_en = 0;
    step(); step(); step();
    chk(!rst_no_o && !wake_o, "R1 in reset", {rst_no_o, wake_o}, 0);
    rst_ni = 1;
    step_to(t + 20);
    chk(!rst_no_o && !wake_o, "R1 supply low hold", {rst_no_o, wake_o}, 0);

    n0 = t;
    supply_ok_i = 1;
    step_to(n0 + 5*U + 2);
    chk(last_rst_rise == n0 + U, "R3 release delay", last_rst_rise, n0 + U);
    chk(last_rise == n0 + 5*U, "R4 restart delay", last_rise, n0 + 5*U);
    chk(wake_in_rst == 0, "R1 wake low during power-up", wake_in_rst, 0);

    // loopback free run
    loop_en = 1;
    c0 = n0 + 5*U;
    step_to(c0 + 28*U + 1);
    chk(last_rise == c0 + 24*U, "R5 period", last_rise, c0 + 24*U);
    chk(last_fall == c0 + 28*U, "R5 duty", last_fall, c0 + 28*U);
    chk(rst_falls == 0, "R10 loopback no reset", rst_falls, 0);
    c4 = c0 + 32*U;
    step_to(c4 + 1);
    loop_en = 0;
    chk(last_rise == c4, "R10 loopback cycle continues", last_rise, c4);

    // sweep of service offsets across the cycle
    for (int j = 0; j < 7; j++) begin
      int c, off, e;
      c = c4 + 8*U*j;
      off = 3 + 11*j;
      e = (off + 3 + LAT < 4*U) ? off + 3 + LAT : 4*U;
      step_to(c + off);
      pulse_wdi();
      step_to(c + 8*U - 1);
      chk(last_fall == c + e, "R6 cut latency", last_fall - c, e);
      chk(last_rise == c, "R5 cycle start unchanged", last_rise - c, 0);
    end

    // two edges in one cycle, none in the next
    c5 = c4 + 56*U;
    step_to(c5 + U);
    pulse_wdi();
    step_to(c5 + 2*U);
    pulse_wdi();
    c6 = c5 + 8*U;
    step_to(c6 + 1);
    chk(last_rise == c6 && rst_falls == 0, "R7 serviced cycle wraps", last_rise, c6);
    c7 = c6 + 8*U;
    step_to(c7 + 1);
    chk(rst_falls == 1 && last_rst_fall == c7, "R7 R8 missed service reset", last_rst_fall, c7);
    step_to(c7 + 5*U + 1);
    chk(last_rst_rise == c7 + U, "R8 reset width", last_rst_rise - c7, U);
    chk(last_rise == c7 + 5*U, "R4 restart after watchdog reset", last_rise - c7, 5*U);
    chk(wake_in_rst == 0, "R9 wake low in reset", wake_in_rst, 0);

    // service in low half
    d0 = c7 + 5*U;
    step_to(d0 + 5*U);
    pulse_wdi();
    d1 = d0 + 8*U;
    step_to(d1 + 1);
    chk(last_rise == d1 && rst_falls == 1, "R6 low-half service", last_rise - d0, 8*U);

    // supply loss mid high phase
    step_to(d1 + U);
    supply_ok_i = 0;
    step();
    chk(!rst_no_o && !wake_o, "R2 R9 supply loss", {rst_no_o, wake_o}, 0);
    step_to(t + 10);
    s = t;
    supply_ok_i = 1;
    step_to(s + 5*U + 1);
    chk(last_rst_rise == s + U, "R3 release after recovery", last_rst_rise - s, U);
    chk(last_rise == s + 5*U, "R4 restart after recovery", last_rise - s, 5*U);

    // slow tick, loopback
    loop_en = 1;
    slow = 1;
    step_to(t + 8*24*U);
    chk(last_per == 24*U, "R11 period scales with tick", last_per, 24*U);
    chk(last_hw == 12*U, "R11 high width scales with tick", last_hw, 12*U);
    chk(rst_falls == 2, "R10 no reset under slow tick", rst_falls, 2);
    while (tick_i) step();
    supply_ok_i = 0;
    step();
    chk(!rst_no_o, "R2 supply loss without tick", rst_no_o, 0);
    chk(wake_in_rst == 0, "R9 wake never high in reset", wake_in_rst, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule